// File: doc/BRIEF.md
# One-Shot Deadline Tick Timer

This block keeps a free-running tick counter and a single compare deadline. Software loads or reads the counter through a plain register port and writes a compare word that arms exactly one interrupt. When the counter arrives at the deadline, the block sets one soft-interrupt bit and emits a one-cycle wake pulse for a halted core. Every further interrupt needs a fresh compare write.

The top bit of the register word is a disable flag. It is shared by the count and compare registers: either write sets or clears it, and a count read shows it. A deadline of zero, or a write that sets the flag, leaves nothing armed. A deadline that is not ahead of the counter when written is not lost. It fires on the next tick.

The deadline tracker is a three-state machine:
- IDLE: nothing is armed.
- ARMED: waiting for count equal to the deadline.
- LATE: the deadline was already passed, so the tracker fires on the next tick.

Transitions:
- A compare write goes to IDLE if the deadline is zero or the flag bit is set. Otherwise it goes to ARMED if the deadline is above the count, and to LATE if not.
- ARMED goes to IDLE and fires when the count matches the deadline while enabled.
- LATE goes to IDLE and fires on a cycle with tick enabled.
- ARMED or LATE goes to IDLE without firing whenever the flag reads set.
- A compare write always overrides the current state.

Top module: `deadline_tick_timer`

## Requirements
- R1: After reset, the count read returns the disable flag (top bit) as 1 and the count field as 0. `softint` and `wake` are 0 and no deadline is armed.
- R2: A count write loads bits W-2:0 into the counter and copies bit W-1 into the disable flag. A count read returns {flag, count}.
- R3: The counter increments by one on each cycle with `tick_en` high, wraps to zero after the all-ones value, and holds when `tick_en` is low.
- R4: A compare write copies bit W-1 into the same disable flag.
- R5: A compare write with a zero deadline field, or with bit W-1 set, cancels any pending deadline, and no interrupt follows.
- R6: A deadline above the count when written fires on the clock edge at which the count equals the deadline. With `tick_en` held high from a count c, `softint` rises d-c+1 edges later.
- R7: A deadline at or below the count when written fires on the first following edge with `tick_en` high.
- R8: Setting the flag with a count write while a deadline is pending cancels it without an interrupt.
- R9: A deadline fires at most once. It does not fire again when the counter wraps past the same value.
- R10: Firing sets only bit SI_BIT of `softint` (16 in the bench configuration). The bit stays set until `si_clr`, a set wins over a clear in the same cycle, and clearing does not re-arm.
- R11: `wake` is high for exactly the one cycle in which the soft-interrupt bit is first set by a firing.
- R12: A compare write replaces any pending deadline. Only the newest one can fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counter advance enable (one tick) |
| cnt_wr | input | 1 | Count register write strobe |
| cmp_wr | input | 1 | Compare register write strobe |
| wr_data | input | W | Write data; top bit is the disable flag |
| cnt_rd_data | output | W | {disable flag, count} |
| si_clr | input | 1 | Clears the soft-interrupt bit |
| softint | output | SI_W | Soft-interrupt vector; only bit SI_BIT is driven |
| wake | output | 1 | One-cycle wake pulse on firing |

## Verification
The assertions check the following on every cycle:
- the counter holds when neither ticking nor written;
- a compare write updates the flag;
- a zero or disabled compare leaves the machine idle;
- a firing returns the machine to IDLE;
- the soft-interrupt bit stays set until cleared;
- the wake pulse is single and coincides with a set bit.

Firing latency against every starting count and deadline, including the late case, is shown only by the bench's sweeps. So are cancellation by a count write, replacement by a second compare, and the absence of a second firing after wrap.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_LATE  = 2'd2
    } dl_state_t;
endpackage

// File: rtl/tick_count_reg.sv
module tick_count_reg #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  logic         cnt_wr,
    input  logic         cmp_wr,
    input  logic [W-1:0] wr_data,
    output logic [W-2:0] count,
    output logic         dis
);
    localparam int CW = W - 1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (cnt_wr) begin
            count <= wr_data[CW-1:0];
        end else if (tick_en) begin
            count <= count + {{(CW-1){1'b0}}, 1'b1};
        end
    end

    // both register writes own the shared flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dis <= 1'b1;
        end else if (cnt_wr || cmp_wr) begin
            dis <= wr_data[W-1];
        end
    end

    a_r3_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_wr && !tick_en) |=> $stable(count));

    a_r4_flag_from_cmp: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_wr && !cnt_wr) |=> (dis == $past(wr_data[W-1])));
endmodule

// File: rtl/tick_deadline_fsm.sv
module tick_deadline_fsm
    import tick_timer_pkg::*;
#(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  logic         cmp_wr,
    input  logic [W-1:0] wr_data,
    input  logic [W-2:0] count,
    input  logic         dis,
    output logic         fire
);
    localparam int CW = W - 1;

    dl_state_t     state, state_nx;
    logic [CW-1:0] deadline;
    logic          cmp_zero;
    logic          cmp_off;

    assign cmp_zero = (wr_data[CW-1:0] == '0);
    assign cmp_off  = wr_data[W-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            deadline <= '0;
        end else begin
            state <= state_nx;
            if (cmp_wr) begin
                deadline <= wr_data[CW-1:0];
            end
        end
    end

    always_comb begin
        fire = 1'b0;
        if (!cmp_wr && !dis) begin
            unique case (state)
                ST_ARMED: fire = (count == deadline);
                ST_LATE:  fire = tick_en;
                default:  fire = 1'b0;
            endcase
        end
    end

    always_comb begin
        state_nx = state;
        if (cmp_wr) begin
            if (cmp_zero || cmp_off) begin
                state_nx = ST_IDLE;
            end else if (wr_data[CW-1:0] > count) begin
                state_nx = ST_ARMED;
            end else begin
                state_nx = ST_LATE;
            end
        end else begin
            unique case (state)
                ST_IDLE:  state_nx = ST_IDLE;
                ST_ARMED: if (dis || fire) state_nx = ST_IDLE;
                ST_LATE:  if (dis || fire) state_nx = ST_IDLE;
                default:  state_nx = ST_IDLE;
            endcase
        end
    end

    a_r5_zero_or_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_wr && (cmp_zero || cmp_off)) |=> (state == ST_IDLE));

    a_r9_idle_after_fire: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (state == ST_IDLE));
endmodule

// File: rtl/tick_softint_reg.sv
module tick_softint_reg #(
    parameter int SI_W   = 32,
    parameter int SI_BIT = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fire,
    input  logic            si_clr,
    output logic [SI_W-1:0] softint,
    output logic            wake
);
    logic si_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            si_q <= 1'b0;
            wake <= 1'b0;
        end else begin
            wake <= fire;
            if (fire) begin
                si_q <= 1'b1;
            end else if (si_clr) begin
                si_q <= 1'b0;
            end
        end
    end

    for (genvar i = 0; i < SI_W; i++) begin : g_si
        if (i == SI_BIT) begin : g_on
            assign softint[i] = si_q;
        end else begin : g_off
            assign softint[i] = 1'b0;
        end
    end

    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (softint[SI_BIT] && !si_clr) |=> softint[SI_BIT]);

    a_r11_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> !wake);

    a_r11_wake_with_bit: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> softint[SI_BIT]);
endmodule

// File: rtl/deadline_tick_timer.sv
module deadline_tick_timer #(
    parameter int W      = 64,
    parameter int SI_W   = 32,
    parameter int SI_BIT = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_en,
    input  logic            cnt_wr,
    input  logic            cmp_wr,
    input  logic [W-1:0]    wr_data,
    output logic [W-1:0]    cnt_rd_data,
    input  logic            si_clr,
    output logic [SI_W-1:0] softint,
    output logic            wake
);
    logic [W-2:0] count;
    logic         dis;
    logic         fire;

    tick_count_reg #(.W(W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .cnt_wr  (cnt_wr),
        .cmp_wr  (cmp_wr),
        .wr_data (wr_data),
        .count   (count),
        .dis     (dis)
    );

    tick_deadline_fsm #(.W(W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .cmp_wr  (cmp_wr),
        .wr_data (wr_data),
        .count   (count),
        .dis     (dis),
        .fire    (fire)
    );

    tick_softint_reg #(.SI_W(SI_W), .SI_BIT(SI_BIT)) u_si (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fire),
        .si_clr  (si_clr),
        .softint (softint),
        .wake    (wake)
    );

    assign cnt_rd_data = {dis, count};
endmodule

// File: tb/deadline_tick_timer_bench.sv
module deadline_tick_timer_bench;
    localparam int CLK_P  = 10;
    localparam int W      = 8;
    localparam int CW     = W - 1;
    localparam int MODC   = 1 << CW;
    localparam int SI_W   = 32;
    localparam int SI_BIT = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            tick_en = 1'b0, cnt_wr = 1'b0, cmp_wr = 1'b0, si_clr = 1'b0;
    logic [W-1:0]    wr_data = '0;
    logic [W-1:0]    cnt_rd_data;
    logic [SI_W-1:0] softint;
    logic            wake;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #(CLK_P/2) clk = ~clk;

    deadline_tick_timer #(.W(W), .SI_W(SI_W), .SI_BIT(SI_BIT)) u_deadline_tick_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_wr(cnt_wr), .cmp_wr(cmp_wr),
        .wr_data(wr_data), .cnt_rd_data(cnt_rd_data), .si_clr(si_clr),
        .softint(softint), .wake(wake)
    );

    localparam logic [SI_W-1:0] SI_MASK = SI_W'(1) << SI_BIT;

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_cnt(logic flag, int val);
        cnt_wr = 1'b1; wr_data = {flag, CW'(val)};
        step();
        cnt_wr = 1'b0;
    endtask

    task automatic wr_cmp(logic flag, int val);
        cmp_wr = 1'b1; wr_data = {flag, CW'(val)};
        step();
        cmp_wr = 1'b0;
    endtask

    task automatic clear_si();
        si_clr = 1'b1;
        step();
        si_clr = 1'b0;
    endtask

    // run with tick_en high, return edges until softint seen (0 if none)
    task automatic run_until_fire(int limit, output int n, output logic w);
        n = 0; w = 1'b0;
        tick_en = 1'b1;
        for (int k = 1; k <= limit; k++) begin
            step();
            if (softint != '0) begin
                n = k; w = wake;
                break;
            end
        end
        tick_en = 1'b0;
    endtask

    initial begin
        while (cyc < 200000) begin
            @(posedge clk);
            cyc++;
        end
        bad++; total++;
        $display("FAIL watchdog: actual=%0d expected=<200000", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        logic w;
        step(); step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1 read", cnt_rd_data, {1'b1, CW'(0)});
        chk("R1 softint", softint, 0);
        chk("R1 wake", wake, 0);
        step();
        chk("R1 no fire", softint, 0);

        // R2 count write / read with both flag values
        wr_cnt(1'b1, 37);
        chk("R2 flag set", cnt_rd_data, {1'b1, CW'(37)});
        wr_cnt(1'b0, 90);
        chk("R2 flag clr", cnt_rd_data, {1'b0, CW'(90)});

        // R3 hold and advance and wrap
        step(); step();
        chk("R3 hold", cnt_rd_data, {1'b0, CW'(90)});
        wr_cnt(1'b0, MODC - 2);
        tick_en = 1'b1; step(); step(); step(); tick_en = 1'b0;
        chk("R3 wrap", cnt_rd_data, {1'b0, CW'(1)});

        // R4 compare write owns the flag
        wr_cmp(1'b1, 5);
        chk("R4 cmp sets flag", cnt_rd_data[W-1], 1);
        wr_cmp(1'b0, 0);
        chk("R4 cmp clears flag", cnt_rd_data[W-1], 0);

        // R5 zero deadline: nothing fires across a full wrap
        run_until_fire(MODC + 20, n, w);
        chk("R5 zero deadline", n, 0);
        // R5 disabled compare with a real deadline
        wr_cnt(1'b0, 3);
        wr_cmp(1'b1, 10);
        run_until_fire(MODC + 20, n, w);
        chk("R5 disabled deadline", n, 0);
        chk("R5 flag reads set", cnt_rd_data[W-1], 1);

        // R8 cancel by count write with flag
        wr_cnt(1'b0, 3);
        wr_cmp(1'b0, 40);
        tick_en = 1'b1; step(); step(); tick_en = 1'b0;
        wr_cnt(1'b1, 5);
        run_until_fire(MODC + 20, n, w);
        chk("R8 cancelled", n, 0);

        // R12 second compare replaces the first
        wr_cnt(1'b0, 10);
        wr_cmp(1'b0, 50);
        wr_cmp(1'b0, 20);
        run_until_fire(MODC + 20, n, w);
        chk("R12 replaced latency", n, 11);
        chk("R10 bit position", softint, SI_MASK);

        // R10 sticky, clear does not re-arm; R9 one-shot across wrap
        step(); step();
        chk("R10 sticky", softint, SI_MASK);
        clear_si();
        chk("R10 cleared", softint, 0);
        run_until_fire(MODC + 20, n, w);
        chk("R9 no refire after wrap", n, 0);

        // R10 set wins over clear in the same cycle
        wr_cnt(1'b0, 60);
        wr_cmp(1'b0, 30);
        si_clr = 1'b1; tick_en = 1'b1;
        step();
        si_clr = 1'b0; tick_en = 1'b0;
        chk("R10 set beats clear", softint, SI_MASK);
        chk("R11 wake with set", wake, 1);
        step();
        chk("R11 wake one cycle", wake, 0);
        clear_si();

        // R6 / R7 sweep over start counts and deadlines
        for (int c0 = 0; c0 < MODC; c0 += 9) begin
            for (int d = 1; d < MODC; d += 7) begin
                int exp_l;
                exp_l = (d > c0) ? (d - c0 + 1) : 1;
                wr_cnt(1'b0, c0);
                wr_cmp(1'b0, d);
                run_until_fire(MODC + 20, n, w);
                if (d > c0) chk("R6 latency", n, exp_l);
                else        chk("R7 late latency", n, exp_l);
                chk("R11 wake at fire", w, 1);
                chk("R3 count after run", cnt_rd_data, {1'b0, CW'((c0 + exp_l) % MODC)});
                clear_si();
                chk("R10 clear", softint, 0);
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule